// File: doc/BRIEF.md
# Multiphase Switch-Drive Sequencer

This block drives the six power switches of a switched-capacitor-inductor step-up converter. A free-running tick counter divides time into switching periods of `PERIOD` clocks. A duty word, sampled once at the start of each period, sets how many of those ticks belong to the charge phase (Phase I). The remaining ticks form the transfer phase (Phase II). A three-bit step counter advances by one at the end of every period, so eight periods make up one full sequence. The step is also presented as a one-hot vector.

During the charge phase the inductor is energised through S1 and S2 in every step. During the transfer phase a different switch set is closed depending on the step, so that charge cascades through the three pumping capacitors and finally reaches the output. At the start of each phase a dead window of `DEAD` clocks holds every gate low. The two phase flags are high only outside that window, so they never overlap.

A controller outside this block supplies the duty word from its regulation loop. The enable input starts the sequence and, when it is dropped, stops it cleanly at the end of the phase in progress.

Top module: `swdrv_seq`

## Requirements
- R1: The step index runs 0,1,…,7,0 and advances by one each time a period's Phase II completes. `step_hot_o` has exactly bit k set when the step is k.
- R2: Within a period of `PERIOD` ticks (tick 0 is the first clock after the period starts), ticks 0 to d−1 are Phase I and ticks d to `PERIOD`−1 are Phase II, where d is the clamped duty.
- R3: Outside dead time in Phase I, `gate_o` equals 6'b000011 (S1 and S2 on) in every step. Gate bit k−1 drives switch Sk.
- R4: Outside dead time in Phase II of steps 0, 2, 4 and 6, `gate_o` equals 6'b000001 (S1 only).
- R5: Outside dead time in Phase II of steps 1 and 5, `gate_o` equals 6'b000110 (S2 and S3).
- R6: Outside dead time in Phase II, step 3 gives 6'b011010 (S2, S4, S5) and step 7 gives 6'b101010 (S2, S4, S6).
- R7: The first `DEAD` ticks of each phase hold `gate_o` at zero with both phase flags low. Elsewhere `ph1_o` is high exactly in Phase I and `ph2_o` exactly in Phase II. The two flags are never high together.
- R8: A duty word below `DEAD`+1 is treated as `DEAD`+1, and one above `PERIOD`−`DEAD`−1 is treated as `PERIOD`−`DEAD`−1. With the defaults (64, 2) this is the range 3 to 61, so a duty of 48 (0.75) passes unchanged.
- R9: The duty word is sampled only on the clock edge that starts a period. Changes during a period do not alter that period's phase lengths.
- R10: While reset is high at a clock edge, the next cycle shows step 0, `gate_o` zero and both flags low. The block then stays idle until enabled.
- R11: With `en_i` low, the sequence stops at the end of the current phase, and from then on all gates and flags are low. If Phase II had completed, the step has advanced; if only Phase I had completed, it has not. Raising `en_i` again starts a new period at Phase I of the held step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable |
| duty_i | input | DUTY_W | Phase I length in ticks, sampled at period start |
| gate_o | output | 6 | Gate drives, bit 0 = S1 … bit 5 = S6 |
| step_o | output | 3 | Current step index |
| step_hot_o | output | 8 | One-hot step |
| ph1_o | output | 1 | Phase I active (outside dead time) |
| ph2_o | output | 1 | Phase II active (outside dead time) |

## Verification
All outputs are decoded from registers without further delay. The first tick of a period therefore appears one cycle after the edge that sampled the enable and duty word, and each later tick follows one cycle after the previous one. A stop or reset shows on the outputs one cycle after the edge that sees it. The driver changes inputs just after a falling edge and pushes one expected output word per cycle, computed from the requirement table for that tick. The monitor pops and compares one word on every falling edge, so each expectation lines up with the cycle its requirement assigns it.

// File: rtl/swdrv_seq.sv
module swdrv_seq #(
  parameter int PERIOD = 64,
  parameter int DEAD   = 2,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [5:0]        gate_o,
  output logic [2:0]        step_o,
  output logic [7:0]        step_hot_o,
  output logic              ph1_o,
  output logic              ph2_o
);
  localparam int TW   = $clog2(PERIOD);
  localparam int DMIN = DEAD + 1;
  localparam int DMAX = PERIOD - DEAD - 1;

  logic          active;
  logic [TW-1:0] tick, dlat, dnext;
  logic [2:0]    step;
  logic          in_p1, in_p2, dead;
  logic [5:0]    p2_set;

  always_comb begin
    if (32'(duty_i) < DMIN)      dnext = TW'(DMIN);
    else if (32'(duty_i) > DMAX) dnext = TW'(DMAX);
    else                         dnext = TW'(duty_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tick   <= '0;
      step   <= '0;
      dlat   <= TW'(DMIN);
    end else if (!active) begin
      if (en_i) begin
        active <= 1'b1;
        tick   <= '0;
        dlat   <= dnext;
      end
    end else if (tick == TW'(PERIOD - 1)) begin
      step   <= step + 3'd1;
      tick   <= '0;
      dlat   <= dnext;
      active <= en_i;
    end else if (!en_i && tick == dlat - 1'b1) begin
      active <= 1'b0;
      tick   <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign in_p1 = active && (tick < dlat);
  assign in_p2 = active && (tick >= dlat);
  assign dead  = (in_p1 && 32'(tick) < DEAD) ||
                 (in_p2 && ({1'b0, tick} < {1'b0, dlat} + (TW+1)'(DEAD)));

  always_comb begin
    case (step)
      3'd1, 3'd5: p2_set = 6'b000110;
      3'd3:       p2_set = 6'b011010;
      3'd7:       p2_set = 6'b101010;
      default:    p2_set = 6'b000001;
    endcase
  end

  assign gate_o     = dead ? 6'b0 : (in_p1 ? 6'b000011 : (in_p2 ? p2_set : 6'b0));
  assign ph1_o      = in_p1 && !dead;
  assign ph2_o      = in_p2 && !dead;
  assign step_o     = step;
  assign step_hot_o = 8'b1 << step;
endmodule

// File: rtl/swdrv_seq_chk.sv
module swdrv_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] gate_o,
  input logic [2:0] step_o,
  input logic [7:0] step_hot_o,
  input logic       ph1_o,
  input logic       ph2_o
);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (gate_o == 6'b0 && step_o == 3'd0));

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst) !(ph1_o && ph2_o));

  // R7
  gate_needs_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_o != 6'b0) |-> (ph1_o || ph2_o));

  // R3
  charge_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    ph1_o |-> gate_o == 6'b000011);

  // R1
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst) $countones(step_hot_o) == 1);

  // R1
  step_increment_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(step_o) |-> step_o == $past(step_o) + 3'd1);

  // R7
  dead_before_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph2_o) |-> $past(gate_o) == 6'b0);

  // R7
  dead_before_charge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph1_o) |-> $past(gate_o) == 6'b0);
endmodule

bind swdrv_seq swdrv_seq_chk u_chk (
  .clk(clk), .rst(rst), .gate_o(gate_o), .step_o(step_o),
  .step_hot_o(step_hot_o), .ph1_o(ph1_o), .ph2_o(ph2_o)
);

// File: tb/tb_swdrv_seq.sv
module tb_swdrv_seq;
  localparam int P  = 64;
  localparam int DT = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [7:0] duty_i = 8'd0;
  logic [5:0] gate_o;
  logic [2:0] step_o;
  logic [7:0] step_hot_o;
  logic       ph1_o, ph2_o;

  int checks = 0;
  int errors = 0;
  int exp_step = 0;
  logic [10:0] qv[$];
  string       qr[$];

  always #5 clk = ~clk;

  swdrv_seq #(.PERIOD(P), .DEAD(DT), .DUTY_W(8)) dut (
    .clk(clk), .rst(rst), .en_i(en_i), .duty_i(duty_i), .gate_o(gate_o),
    .step_o(step_o), .step_hot_o(step_hot_o), .ph1_o(ph1_o), .ph2_o(ph2_o)
  );

  // R8: clamp window
  function automatic int clampd(int d);
    if (d < DT + 1) return DT + 1;
    if (d > P - DT - 1) return P - DT - 1;
    return d;
  endfunction

  // R3 R4 R5 R6: switch table
  function automatic logic [5:0] pat(int s, bit p1);
    if (p1) return 6'b000011;
    case (s)
      1, 5:    return 6'b000110;
      3:       return 6'b011010;
      7:       return 6'b101010;
      default: return 6'b000001;
    endcase
  endfunction

  function automatic string ptag(int s, bit p1, bit dd);
    if (dd) return "R7";
    if (p1) return "R3";
    if (s == 3 || s == 7) return "R6";
    if (s == 1 || s == 5) return "R5";
    return "R4";
  endfunction

  // R2: tick t of a period with clamped duty d
  task automatic push_tick(int t, int d, int s, string extra);
    bit p1 = (t < d);
    bit dd = p1 ? (t < DT) : (t < d + DT);
    logic [5:0] g = dd ? 6'b0 : pat(s, p1);
    qv.push_back({g, 3'(s), p1 && !dd, !p1 && !dd});
    qr.push_back({ptag(s, p1, dd), " R2 ", extra});
  endtask

  task automatic push_idle(string r);
    qv.push_back({6'b0, 3'(exp_step), 1'b0, 1'b0});
    qr.push_back(r);
  endtask

  task automatic tick_wait(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    en_i = 1'b0;
    for (int i = 0; i < n; i++) push_idle("R11");
    tick_wait(n);
  endtask

  task automatic run_period(int d, string extra);
    int cd = clampd(d);
    en_i = 1'b1;
    duty_i = 8'(d);
    for (int t = 0; t < P; t++) push_tick(t, cd, exp_step, extra);
    tick_wait(4);
    duty_i = ~8'(d); // R9: mid-period change must be ignored
    tick_wait(P - 4);
    exp_step = (exp_step + 1) % 8;
  endtask

  // R11: stop after Phase I
  task automatic stop_mid(int d);
    int cd = clampd(d);
    en_i = 1'b1;
    duty_i = 8'(d);
    for (int t = 0; t < cd; t++) push_tick(t, cd, exp_step, "R11");
    for (int i = 0; i < 3; i++) push_idle("R11");
    tick_wait(1);
    en_i = 1'b0;
    tick_wait(cd + 2);
  endtask

  // R10: reset during a run
  task automatic reset_mid(int d);
    int cd = clampd(d);
    en_i = 1'b1;
    duty_i = 8'(d);
    for (int t = 0; t < 10; t++) push_tick(t, cd, exp_step, "R10");
    tick_wait(10);
    rst = 1'b1;
    en_i = 1'b0;
    exp_step = 0;
    push_idle("R10");
    push_idle("R10");
    tick_wait(2);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) push_idle("R10");
    tick_wait(3);
  endtask

  always @(negedge clk) begin
    if (qv.size() > 0) begin
      logic [10:0] v;
      string r;
      v = qv.pop_front();
      r = qr.pop_front();
      checks++;
      if (gate_o !== v[10:5] || ph1_o !== v[1] || ph2_o !== v[0]) begin
        errors++;
        $display("FAIL %s gate/ph1/ph2 actual %b/%b/%b expected %b/%b/%b at %0t",
                 r, gate_o, ph1_o, ph2_o, v[10:5], v[1], v[0], $time);
      end else if (step_o !== v[4:2] || step_hot_o !== (8'b1 << v[4:2])) begin
        errors++;
        $display("FAIL R1 step/hot actual %0d/%b expected %0d/%b at %0t",
                 step_o, step_hot_o, v[4:2], 8'b1 << v[4:2], $time);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick_wait(1);
    rst = 1'b1;
    push_idle("R10");
    push_idle("R10");
    tick_wait(2);
    rst = 1'b0;
    idle(4);
    run_period(32, "R1");
    run_period(48, "R8");
    run_period(0, "R8");
    run_period(255, "R8");
    run_period(64, "R8");
    run_period(3, "R9");
    run_period(2, "R8");
    run_period(20, "R1");
    run_period(10, "R1");
    idle(3);
    stop_mid(40);
    run_period(40, "R11");
    run_period(16, "R6");
    run_period(61, "R8");
    reset_mid(30);
    run_period(25, "R10");
    idle(3);
    tick_wait(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule